// File: doc/BRIEF.md
# Timer/Counter with Shared Prescaler

An 8-bit up-counter that either counts instruction cycles or counts edges of an external pin. The pin is synchronized to the core clock, and a select input chooses the active edge. When the counter wraps from all ones to zero, it sets an overflow flag. The flag stays set until software clears it. Software can load the counter at any time. After a load, the counter does not count for the next two instruction cycles, which gives a fixed and known dead time after the write.

A single power-of-two prescaler is given to exactly one of two users at a time: the counter or the watchdog. When the counter owns it, the prescaler divides the counter's input events. When the watchdog owns it, it divides the overflows of the watchdog's base counter, which lengthens the time-out. Software cannot read or write the prescaler. A load of the counter clears it when the counter owns it. A watchdog clear strobe clears it when the watchdog owns it. The watchdog's oscillator is outside the block and arrives as a single-cycle tick.

Top module: `tmr_unit`

## Requirements
- R1: After reset `cnt_o` is 0, `ovf_flag_o` is 0 and `wdt_timeout_o` is 0.
- R2: With `mode_pin_i`=0 and `psc_wdt_i`=1, each clock with `cyc_en_i`=1 adds one to `cnt_o` once the post-write block has expired. A clock with `cyc_en_i`=0 leaves the count unchanged.
- R3: With `mode_pin_i`=1, the block counts edges of `ext_pin_i`: rising edges when `edge_fall_i`=0, falling edges when it is 1. A pin change made before clock edge k appears on `cnt_o` after edge k+2. `cyc_en_i` does not count in this mode.
- R4: With `psc_wdt_i`=0, the counter advances once per 2^(`rate_i`+1) input events, counted from the last prescaler clear.
- R5: A pulse on `wr_cnt_i` loads `wr_data_i` into `cnt_o` at the next edge. It then blocks increments until two clocks with `cyc_en_i`=1 have passed. When `psc_wdt_i`=0, it also clears the prescaler.
- R6: A wrap of `cnt_o` from FFh to 00h by an increment sets `ovf_flag_o`. Only `flag_clr_i` clears the flag, and a set in the same cycle wins over the clear. A load never sets the flag.
- R7: Apart from a load, `cnt_o` changes by at most one per clock, wrapping modulo 256.
- R8: The watchdog base counter (`WDT_W` bits) counts `wdt_tick_i` pulses. With `psc_wdt_i`=0, `wdt_timeout_o` rises on tick 2^`WDT_W` after a clear. With `psc_wdt_i`=1, it rises on tick 2^(`WDT_W`+`rate_i`). The output then stays high until `wdt_clr_i`.
- R9: `wdt_clr_i` clears the base counter and `wdt_timeout_o`. It clears the prescaler only when `psc_wdt_i`=1; when the counter owns the prescaler, its phase is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | One-clock pulse per instruction cycle |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| mode_pin_i | input | 1 | 0: count instruction cycles, 1: count pin edges |
| edge_fall_i | input | 1 | 0: rising pin edge, 1: falling pin edge |
| psc_wdt_i | input | 1 | 0: prescaler serves counter, 1: prescaler serves watchdog |
| rate_i | input | $clog2(PSC_W) | Prescaler rate select |
| wr_cnt_i | input | 1 | Counter load strobe |
| wr_data_i | input | CNT_W | Counter load value |
| flag_clr_i | input | 1 | Overflow flag clear strobe |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| wdt_tick_i | input | 1 | Watchdog oscillator tick, one clock wide |
| cnt_o | output | CNT_W | Counter value |
| ovf_flag_o | output | 1 | Overflow flag |
| wdt_timeout_o | output | 1 | Watchdog time-out, held until cleared |

## Verification
The bench builds the block with `CNT_W`=8, `PSC_W`=8 and `WDT_W`=4. The narrow watchdog base lets every one of the eight rate settings reach a time-out within a few thousand ticks. The bench sweeps both prescaler owners across all eight rates and two start values. It predicts each final count from the division ratio less the events lost to the post-write block, so both wrap and no-wrap cases are covered. Pin counting is run for both edges, with and without prescaling, and a cycle-exact check confirms the synchronizer latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic {SRC_CYCLE = 1'b0, SRC_PIN = 1'b1} tmr_src_e;
  typedef enum logic {OWNER_TMR = 1'b0, OWNER_WDT = 1'b1} psc_owner_e;
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic evt_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  // sh_q[STAGES-1] is the settled level, sh_q[STAGES] the previous one
  always_comb begin
    if (fall_sel_i) evt_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
    else            evt_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  end
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   in_i,
  input  logic [$clog2(W+1)-1:0] div_i,
  output logic                   out_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (in_i)  cnt_q <= cnt_q + 1'b1;
  end

  // div_i == W wraps the shift to zero, giving an all-ones mask
  assign mask  = (W'(1) << div_i) - W'(1);
  assign out_o = in_i & ~clr_i & ((cnt_q & mask) == mask);
endmodule

// File: rtl/tmr_count_reg.sv
module tmr_count_reg #(
  parameter int W   = 8,
  parameter int INH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  input  logic         cyc_i,
  input  logic         flag_clr_i,
  output logic [W-1:0] cnt_o,
  output logic         flag_o
);
  localparam int IW = $clog2(INH + 1);

  logic [W-1:0]  cnt_q;
  logic [IW-1:0] inh_q;
  logic          inc_ok;
  logic          flag_q;

  assign inc_ok = inc_i & ~wr_i & (inh_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      inh_q <= '0;
    end else if (wr_i) begin
      cnt_q <= wdata_i;
      inh_q <= IW'(INH);
    end else begin
      if (inc_ok)                  cnt_q <= cnt_q + 1'b1;
      if (cyc_i && inh_q != '0)    inh_q <= inh_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (inc_ok && &cnt_q)   flag_q <= 1'b1;
    else if (flag_clr_i)         flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tmr_wdt_base.sv
module tmr_wdt_base #(
  parameter int W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  input  logic fire_i,
  output logic ovf_o,
  output logic timeout_o
);
  logic [W-1:0] cnt_q;
  logic         to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_o = tick_i & ~clr_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     to_q <= 1'b0;
    else if (clr_i)  to_q <= 1'b0;
    else if (fire_i) to_q <= 1'b1;
  end

  assign timeout_o = to_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PSC_W   = 8,
  parameter int WDT_W   = 8,
  parameter int SYNC_W  = 2,
  parameter int INH_CYC = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cyc_en_i,
  input  logic                     ext_pin_i,
  input  logic                     mode_pin_i,
  input  logic                     edge_fall_i,
  input  logic                     psc_wdt_i,
  input  logic [$clog2(PSC_W)-1:0] rate_i,
  input  logic                     wr_cnt_i,
  input  logic [CNT_W-1:0]         wr_data_i,
  input  logic                     flag_clr_i,
  input  logic                     wdt_clr_i,
  input  logic                     wdt_tick_i,
  output logic [CNT_W-1:0]         cnt_o,
  output logic                     ovf_flag_o,
  output logic                     wdt_timeout_o
);
  localparam int DIV_W = $clog2(PSC_W + 1);

  tmr_src_e         src_sel;
  psc_owner_e       owner;
  logic             pin_evt;
  logic             src_evt;
  logic             psc_in, psc_out, psc_clr;
  logic [DIV_W-1:0] div_sel;
  logic             tmr_inc;
  logic             wdt_ovf, wdt_fire;

  assign src_sel = tmr_src_e'(mode_pin_i);
  assign owner   = psc_owner_e'(psc_wdt_i);

  tmr_edge_sync #(.STAGES(SYNC_W)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (ext_pin_i),
    .fall_sel_i (edge_fall_i),
    .evt_o      (pin_evt)
  );

  assign src_evt = (src_sel == SRC_PIN) ? pin_evt : cyc_en_i;

  // prescaler routing by owner
  always_comb begin
    if (owner == OWNER_WDT) begin
      psc_in   = wdt_ovf;
      div_sel  = DIV_W'(rate_i);
      psc_clr  = wdt_clr_i;
      tmr_inc  = src_evt;
      wdt_fire = psc_out;
    end else begin
      psc_in   = src_evt;
      div_sel  = DIV_W'(rate_i) + DIV_W'(1);
      psc_clr  = wr_cnt_i;
      tmr_inc  = psc_out;
      wdt_fire = wdt_ovf;
    end
  end

  tmr_prescaler #(.W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (psc_clr),
    .in_i   (psc_in),
    .div_i  (div_sel),
    .out_o  (psc_out)
  );

  tmr_count_reg #(.W(CNT_W), .INH(INH_CYC)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_cnt_i),
    .wdata_i    (wr_data_i),
    .inc_i      (tmr_inc),
    .cyc_i      (cyc_en_i),
    .flag_clr_i (flag_clr_i),
    .cnt_o      (cnt_o),
    .flag_o     (ovf_flag_o)
  );

  tmr_wdt_base #(.W(WDT_W)) u_wdt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (wdt_tick_i),
    .clr_i     (wdt_clr_i),
    .fire_i    (wdt_fire),
    .ovf_o     (wdt_ovf),
    .timeout_o (wdt_timeout_o)
  );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cyc_en_i,
  input logic             mode_pin_i,
  input logic             wr_cnt_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic             flag_clr_i,
  input logic             wdt_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic             ovf_flag_o,
  input logic             wdt_timeout_o
);
  always_comb begin
    if (!rst_ni) begin
      assert_reset_idle_R1: assert (cnt_o == '0 && !ovf_flag_o && !wdt_timeout_o);
    end
  end

  assert_no_cycle_no_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_pin_i && !cyc_en_i && !wr_cnt_i) |=> $stable(cnt_o));

  assert_load_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_i |=> cnt_o == $past(wr_data_i));

  assert_load_blocks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_cnt_i) && !wr_cnt_i) |=> $stable(cnt_o));

  assert_wrap_sets_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0 && $past(&cnt_o) && !$past(wr_cnt_i)) |-> ovf_flag_o);

  assert_flag_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_flag_o && !flag_clr_i) |=> ovf_flag_o);

  assert_step_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_cnt_i) |-> (cnt_o == $past(cnt_o) || cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  assert_timeout_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_timeout_o && !wdt_clr_i) |=> wdt_timeout_o);

  assert_clear_drops_timeout_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_clr_i |=> !wdt_timeout_o);
endmodule

bind tmr_unit tmr_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cyc_en_i      (cyc_en_i),
  .mode_pin_i    (mode_pin_i),
  .wr_cnt_i      (wr_cnt_i),
  .wr_data_i     (wr_data_i),
  .flag_clr_i    (flag_clr_i),
  .wdt_clr_i     (wdt_clr_i),
  .cnt_o         (cnt_o),
  .ovf_flag_o    (ovf_flag_o),
  .wdt_timeout_o (wdt_timeout_o)
);

// File: tb/tb_tmr_unit.sv
module tb_tmr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WDT_W      = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_en = 1'b0, ext_pin = 1'b0, mode_pin = 1'b0, edge_fall = 1'b0;
  logic       psc_wdt = 1'b1;
  logic [2:0] rate = 3'd0;
  logic       wr = 1'b0, flag_clr = 1'b0, wdt_clr = 1'b0, wdt_tick = 1'b0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] cnt;
  logic       flag, timeout;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_unit #(.CNT_W(8), .PSC_W(8), .WDT_W(WDT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cyc_en_i(cyc_en), .ext_pin_i(ext_pin),
    .mode_pin_i(mode_pin), .edge_fall_i(edge_fall), .psc_wdt_i(psc_wdt),
    .rate_i(rate), .wr_cnt_i(wr), .wr_data_i(wdata), .flag_clr_i(flag_clr),
    .wdt_clr_i(wdt_clr), .wdt_tick_i(wdt_tick), .cnt_o(cnt),
    .ovf_flag_o(flag), .wdt_timeout_o(timeout)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one clock of strobes, driven at the falling edge
  task automatic drv(input logic c, input logic t, input logic fc, input logic wc);
    @(negedge clk);
    cyc_en = c; wdt_tick = t; flag_clr = fc; wdt_clr = wc; wr = 1'b0;
  endtask

  task automatic load(input logic [7:0] d);
    @(negedge clk);
    cyc_en = 1'b0; wdt_tick = 1'b0; flag_clr = 1'b0; wdt_clr = 1'b0;
    wr = 1'b1; wdata = d;
  endtask

  task automatic settle();
    drv(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drv(1'b0, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    chk("R1 cnt", cnt, 0);
    chk("R1 flag", flag, 0);
    chk("R1 timeout", timeout, 0);
    @(negedge clk); rst_n = 1'b1;
    settle();

    // R2 / R4 / R5 / R6: owner x rate x start sweep, timer mode
    for (int own = 0; own < 2; own++) begin
      for (int r = 0; r < 8; r++) begin
        for (int si = 0; si < 2; si++) begin
          int s, n, d, inc, tot;
          s = (si == 0) ? 0 : 240;
          n = 40 + r * 45 + own * 7;
          d = (own == 1) ? 1 : (2 << r);
          @(negedge clk); psc_wdt = own[0]; rate = r[2:0]; mode_pin = 1'b0;
          drv(1'b0, 1'b0, 1'b1, 1'b0);
          load(s[7:0]);
          for (int i = 0; i < n; i++) drv(1'b1, 1'b0, 1'b0, 1'b0);
          settle();
          inc = 0;
          for (int k = 1; k <= n / d; k++) if (k * d > 2) inc++;
          tot = s + inc;
          if (own == 1) chk("R2 count", cnt, tot % 256);
          else          chk("R4 count", cnt, tot % 256);
          chk("R6 flag", flag, (tot > 255) ? 1 : 0);
        end
      end
    end

    // R6: set wins over clear; load never sets
    @(negedge clk); psc_wdt = 1'b1; mode_pin = 1'b0;
    drv(1'b0, 1'b0, 1'b1, 1'b0);
    load(8'hFF);
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    drv(1'b1, 1'b0, 1'b1, 1'b0);
    settle();
    chk("R6 wrap cnt", cnt, 0);
    chk("R6 set beats clear", flag, 1);
    drv(1'b0, 1'b0, 1'b1, 1'b0);
    load(8'hFF);
    load(8'h00);
    settle();
    chk("R6 load no flag", flag, 0);
    chk("R5 load value", cnt, 0);
    // R2: no cycle enable, no count
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) drv(1'b0, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R2 idle", cnt, 0);

    // R3: pin counting, both edges, bypass and divide-by-2
    for (int e = 0; e < 2; e++) begin
      for (int own = 0; own < 2; own++) begin
        int m;
        m = 5 + 2 * e + 4 * own;
        @(negedge clk); mode_pin = 1'b1; edge_fall = e[0]; psc_wdt = own[0]; rate = 3'd0;
        load(8'd0);
        drv(1'b1, 1'b0, 1'b0, 1'b0);
        drv(1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 2 * m; i++) begin
          @(negedge clk); ext_pin = ~ext_pin;
          for (int j = 0; j < 3; j++) drv(1'b1, 1'b0, 1'b0, 1'b0);
        end
        for (int j = 0; j < 3; j++) settle();
        chk("R3 pin edges", cnt, (own == 1) ? m : m / 2);
      end
    end

    // R3: latency, rising edge, bypass
    @(negedge clk); edge_fall = 1'b0; psc_wdt = 1'b1; ext_pin = 1'b0;
    load(8'd7);
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    for (int j = 0; j < 4; j++) settle();
    @(negedge clk); ext_pin = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R3 latency hold", cnt, 7);
    @(negedge clk); chk("R3 latency step", cnt, 8);
    // falling selected: rising edge ignored
    @(negedge clk); edge_fall = 1'b1; ext_pin = 1'b0;
    for (int j = 0; j < 4; j++) settle();
    chk("R3 falling counted", cnt, 9);
    @(negedge clk); ext_pin = 1'b1;
    for (int j = 0; j < 4; j++) settle();
    chk("R3 rising ignored", cnt, 9);
    @(negedge clk); ext_pin = 1'b0; mode_pin = 1'b0; edge_fall = 1'b0;
    for (int j = 0; j < 4; j++) settle();

    // R8: watchdog, no prescaler
    @(negedge clk); psc_wdt = 1'b0;
    drv(1'b0, 1'b0, 1'b0, 1'b1);
    ticks((1 << WDT_W) - 1);
    settle();
    chk("R8 before timeout", timeout, 0);
    ticks(1);
    settle();
    chk("R8 timeout", timeout, 1);
    for (int j = 0; j < 3; j++) settle();
    chk("R8 timeout held", timeout, 1);
    drv(1'b0, 1'b0, 1'b0, 1'b1);
    settle();
    chk("R9 clear timeout", timeout, 0);

    // R8: watchdog with prescaler, all rates
    for (int r = 0; r < 8; r++) begin
      int t;
      t = (1 << WDT_W) << r;
      @(negedge clk); psc_wdt = 1'b1; rate = r[2:0];
      drv(1'b0, 1'b0, 1'b0, 1'b1);
      ticks(t - 1);
      settle();
      chk("R8 scaled before", timeout, 0);
      ticks(1);
      settle();
      chk("R8 scaled timeout", timeout, 1);
    end

    // R9: clear keeps timer-owned prescaler phase
    @(negedge clk); psc_wdt = 1'b0; rate = 3'd1; mode_pin = 1'b0;
    load(8'd0);
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    drv(1'b0, 1'b0, 1'b0, 1'b1);
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    drv(1'b1, 1'b0, 1'b0, 1'b0);
    settle();
    chk("R9 timer phase kept", cnt, 1);

    // R9: clear resets watchdog-owned prescaler
    @(negedge clk); psc_wdt = 1'b1; rate = 3'd1;
    drv(1'b0, 1'b0, 1'b0, 1'b1);
    ticks(1 << WDT_W);
    drv(1'b0, 1'b0, 1'b0, 1'b1);
    ticks(1 << WDT_W);
    settle();
    chk("R9 wdt prescaler cleared", timeout, 0);
    ticks(1 << WDT_W);
    settle();
    chk("R9 wdt after clear", timeout, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule